// File: doc/BRIEF.md
# Page-Buffered Byte-Wide Nonvolatile Memory Controller

This block is the device-side control logic of a byte-wide nonvolatile memory. It sits behind an active-low chip select, output enable and write strobe and a 16-bit address. The bus pins are sampled on the block clock. A write strobe counts only when chip select and write strobe are both low and output enable is high. It also has to last long enough to pass a noise filter. A valid write loads one byte into a page buffer. The buffer is selected by the low address bits.

Further loads to the same page may follow for as long as each one arrives inside a load window, counted in clock cycles. When the window runs out with no new load, the block goes busy for a programming time, also counted in clock cycles. At the end of that time it copies every loaded byte into the storage array.

While the block is busy, any read returns a status byte and not array data. The top bit is the inverse of bit 7 of the last loaded byte. The next bit flips on every new read. The read data port is a plain output with a separate drive-enable flag, which stands in for a pin that is released to high impedance.

Top module: `eeprom_page_ctl`

## Requirements
- R1: A write is considered only on a sampled cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. Holding `oe_n` low or `ce_n` high while `we_n` is low loads nothing and never raises `busy`.
- R2: A write strobe that is active for fewer than MIN_LOW consecutive sampled cycles (default 2) is discarded. It loads nothing and does not raise `busy`.
- R3: The address of a load is the value of `addr` on the first active cycle of the strobe. The data is the value of `din` on the last active cycle before the strobe ends.
- R4: A load writes page-buffer entry `addr[6:0]`. The first load fixes the page `addr[15:7]`. A later load to another page is ignored and does not restart the window. A repeated load to the same entry keeps the newer byte.
- R5: `busy` rises WIN_CYC+1 cycles (default 21) after the cycle in which the last accepted strobe reached MIN_LOW active cycles. Loads that keep arriving inside the window hold programming off for any length of time.
- R6: `busy` stays high for exactly PROG_CYC cycles (default 50). When it falls, the loaded entries, and only those, are stored in the array.
- R7: Write strobes that start while `busy` is high are ignored. They load nothing and do not start a new page.
- R8: A read while `busy` returns a status byte. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5..0 are zero.
- R9: Bit 6 of the status byte inverts at the start of each new read while `busy`, holds during one read, and is no longer reported once `busy` is low.
- R10: A read (`ce_n`=0 and `oe_n`=0) sets `dout_en` one cycle after the sampling edge. `dout` then carries the array byte at `addr[ARR_AW-1:0]` (default 9 bits, so addresses alias modulo 512). When no read is active, `dout_en` is 0 and `dout` is 0.
- R11: After reset `busy` and `dout_en` are 0, and every array byte reads as 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Byte address; bits 15..7 page, 6..0 byte in page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High when `dout` would drive the bus |
| busy | output | 1 | Internal programming in progress |

## Verification
The bench drives the pins on falling clock edges. On every rising edge it steps a behavioural model made of integers, queues and an associative page map, and it compares `busy`, `dout_en` and `dout` with that model on the next falling edge. The timings the model predicts are these:
- Read data and status are due one edge after the first sampled read cycle.
- A load is taken on the MIN_LOW-th active edge of its strobe.
- `busy` rises WIN_CYC+1 edges after that and falls PROG_CYC edges later.
- Committed bytes appear on the first read sampled after the fall.

Directed reads with fixed expected bytes are placed after those points. They cover the ignored-write cases and confirm through the read port that the array was left untouched.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [1:0] {
        EP_IDLE = 2'd0,
        EP_LOAD = 2'd1,
        EP_PROG = 2'd2
    } ep_state_e;

    localparam logic [7:0] EP_ERASED = 8'hFF;

endpackage

// File: rtl/ep_bus_decode.sv
module ep_bus_decode #(
    parameter int ADDR_W  = 16,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_qual,
    output logic              wr_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_act,
    output logic              rd_start
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic              wr_prev;
        logic              rd_prev;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] adr;
        logic [7:0]        dat;
    } dec_s;

    dec_s q, d;
    logic wr_act;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign rd_act   = !ce_n && !oe_n;
    assign rd_start = rd_act && !q.rd_prev;
    assign wr_qual  = wr_act && (q.cnt == CNT_W'(MIN_LOW - 1));
    assign wr_end   = !wr_act && q.wr_prev && (q.cnt == CNT_W'(MIN_LOW));
    assign wr_addr  = (wr_act && !q.wr_prev) ? addr : q.adr;
    assign wr_data  = q.dat;

    always_comb begin
        d         = q;
        d.wr_prev = wr_act;
        d.rd_prev = rd_act;
        if (wr_act) begin
            if (q.cnt != CNT_W'(MIN_LOW)) d.cnt = q.cnt + 1'b1;
            d.dat = din;
            if (!q.wr_prev) d.adr = addr;
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // a strobe qualifies at most once
    assert_qual_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_qual |=> !wr_qual);

    // an accepted strobe end follows an active cycle
    assert_end_after_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_qual |=> (wr_act || wr_end));

endmodule

// File: rtl/ep_page_buf.sv
module ep_page_buf #(
    parameter int PG_AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [PG_AW-1:0] wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic             clr_i,
    output logic [7:0]       data_o  [1<<PG_AW],
    output logic [(1<<PG_AW)-1:0] valid_o
);
    localparam int PG_SZ = 1 << PG_AW;

    for (genvar g = 0; g < PG_SZ; g++) begin : g_ent
        logic [7:0] dat_d, dat_q;
        logic       vld_d, vld_q;

        always_comb begin
            dat_d = dat_q;
            vld_d = vld_q;
            if (clr_i) begin
                vld_d = 1'b0;
            end else if (wr_i && (wr_idx_i == PG_AW'(g))) begin
                dat_d = wr_data_i;
                vld_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dat_q <= '0;
                vld_q <= 1'b0;
            end else begin
                dat_q <= dat_d;
                vld_q <= vld_d;
            end
        end

        assign data_o[g]  = dat_q;
        assign valid_o[g] = vld_q;
    end

    // loading and clearing never meet
    assert_load_clear_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && clr_i));

    // after a clear the page is empty
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_o == '0));

endmodule

// File: rtl/ep_array.sv
module ep_array #(
    parameter int ARR_AW = 9,
    parameter int PG_AW  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [ARR_AW-PG_AW-1:0] page_i,
    input  logic [7:0]              buf_data_i [1<<PG_AW],
    input  logic [(1<<PG_AW)-1:0]   buf_valid_i,
    input  logic [ARR_AW-1:0]       rd_addr_i,
    output logic [7:0]              rd_data_o
);
    import eeprom_pkg::*;

    localparam int ARR_N = 1 << ARR_AW;
    localparam int PG_SZ = 1 << PG_AW;

    logic [7:0] mem_q [ARR_N];
    logic [7:0] mem_d [ARR_N];

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int i = 0; i < PG_SZ; i++) begin
                if (buf_valid_i[i]) mem_d[{page_i, PG_AW'(i)}] = buf_data_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_N; i++) mem_q[i] <= EP_ERASED;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl #(
    parameter int ADDR_W   = 16,
    parameter int PG_AW    = 7,
    parameter int ARR_AW   = 9,
    parameter int WIN_CYC  = 20,
    parameter int PROG_CYC = 50,
    parameter int MIN_LOW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    import eeprom_pkg::*;

    localparam int PAGE_W = ADDR_W - PG_AW;
    localparam int PG_SZ  = 1 << PG_AW;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int PRG_W  = $clog2(PROG_CYC + 1);

    typedef struct packed {
        ep_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [PG_AW-1:0]  idx;
        logic [WIN_W-1:0]  win;
        logic [PRG_W-1:0]  prg;
        logic              acc;
        logic              last7;
        logic              tog;
        logic [7:0]        dout;
        logic              doe;
    } ctl_s;

    ctl_s q, d;

    logic              wr_qual, wr_end, rd_act, rd_start;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, arr_rd;
    logic              buf_wr, commit;
    logic [7:0]        buf_data  [PG_SZ];
    logic [PG_SZ-1:0]  buf_valid;

    ep_bus_decode #(.ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_qual(wr_qual), .wr_end(wr_end),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_act(rd_act), .rd_start(rd_start)
    );

    ep_page_buf #(.PG_AW(PG_AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_i(buf_wr), .wr_idx_i(q.idx),
        .wr_data_i(wr_data), .clr_i(commit), .data_o(buf_data), .valid_o(buf_valid)
    );

    ep_array #(.ARR_AW(ARR_AW), .PG_AW(PG_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit_i(commit),
        .page_i(q.page[ARR_AW-PG_AW-1:0]), .buf_data_i(buf_data),
        .buf_valid_i(buf_valid), .rd_addr_i(addr[ARR_AW-1:0]), .rd_data_o(arr_rd)
    );

    always_comb begin
        d      = q;
        buf_wr = 1'b0;
        commit = 1'b0;

        // write side: page load, window and programming time
        if (q.st == EP_PROG) begin
            d.acc = 1'b0;
            if (q.prg == PRG_W'(PROG_CYC - 1)) begin
                commit = 1'b1;
                d.st   = EP_IDLE;
            end else begin
                d.prg = q.prg + 1'b1;
            end
        end else begin
            if (wr_qual) begin
                if (q.st == EP_IDLE || wr_addr[ADDR_W-1:PG_AW] == q.page) begin
                    d.acc  = 1'b1;
                    d.page = wr_addr[ADDR_W-1:PG_AW];
                    d.idx  = wr_addr[PG_AW-1:0];
                    d.win  = '0;
                    d.st   = EP_LOAD;
                end
            end else if (q.st == EP_LOAD) begin
                if (q.win == WIN_W'(WIN_CYC) && !q.acc) begin
                    d.st  = EP_PROG;
                    d.prg = '0;
                end else if (q.win != WIN_W'(WIN_CYC)) begin
                    d.win = q.win + 1'b1;
                end
            end
            if (wr_end && q.acc) begin
                buf_wr  = 1'b1;
                d.last7 = wr_data[7];
                d.acc   = 1'b0;
            end
        end

        // read side: array data or status byte
        d.doe  = rd_act;
        d.dout = '0;
        if (rd_act) begin
            if (q.st == EP_PROG) begin
                if (rd_start) d.tog = ~q.tog;
                d.dout = {~q.last7, d.tog, 6'b0};
            end else begin
                d.dout = arr_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= EP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st == EP_PROG);
    assign dout    = q.dout;
    assign dout_en = q.doe;

    // a fresh accepted load keeps programming off in the next cycle
    assert_load_defers_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_qual && !busy) |=> !busy);

    // busy is held until the programming count is used up
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);

    // the array is written only at the close of a busy period
    assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (busy && !(wr_end && q.acc)));

    // no byte enters the page buffer while programming
    assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr);

    // toggle state is steady within one read
    assert_tog_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !rd_start) |=> $stable(q.tog));

    // released bus carries zero
    assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

endmodule

// File: tb/eeprom_page_ctl_tb.sv
module eeprom_page_ctl_tb;

    localparam int WIN  = 20;
    localparam int PRG  = 50;
    localparam int MINL = 2;
    localparam int ARRN = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_page_ctl #(.ADDR_W(16), .PG_AW(7), .ARR_AW(9), .WIN_CYC(WIN),
                      .PROG_CYC(PRG), .MIN_LOW(MINL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_arr [ARRN];
    logic [7:0]  m_pbuf [int];
    logic [15:0] m_cap;
    logic [8:0]  m_page;
    logic [6:0]  m_idx;
    logic [7:0]  m_din, e_dout;
    int          m_low, m_idle, m_prog;
    bit          m_pw, m_pr, m_load, m_acc, m_busy, m_tog, m_last7, e_oe;
    bit          s_w, s_r, s_q, s_e;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_arr[i]) m_arr[i] = 8'hFF;
            m_pbuf.delete();
            m_cap = '0; m_page = '0; m_idx = '0; m_din = '0; e_dout = '0;
            m_low = 0; m_idle = 0; m_prog = 0;
            m_pw = 0; m_pr = 0; m_load = 0; m_acc = 0; m_busy = 0;
            m_tog = 0; m_last7 = 0; e_oe = 0;
        end else begin
            s_w = !ce_n && !we_n && oe_n;
            s_r = !ce_n && !oe_n;
            if (s_w && !m_pw) m_cap = addr;
            s_q = s_w && (m_low == MINL - 1);
            s_e = !s_w && m_pw && (m_low >= MINL);
            e_oe = s_r;
            if (s_r) begin
                if (m_busy) begin
                    if (!m_pr) m_tog = !m_tog;
                    e_dout = {!m_last7, m_tog, 6'b0};
                end else begin
                    e_dout = m_arr[addr[8:0]];
                end
            end else begin
                e_dout = 8'h00;
            end
            if (m_busy) begin
                m_acc = 0;
                if (m_prog == PRG - 1) begin
                    foreach (m_pbuf[i]) m_arr[(int'(m_page) * 128 + i) % ARRN] = m_pbuf[i];
                    m_pbuf.delete();
                    m_busy = 0;
                    m_load = 0;
                end else begin
                    m_prog++;
                end
            end else begin
                if (s_q) begin
                    if (!m_load || m_cap[15:7] == m_page) begin
                        m_acc = 1; m_page = m_cap[15:7]; m_idx = m_cap[6:0];
                        m_idle = 0; m_load = 1;
                    end
                end else if (m_load) begin
                    if (m_idle == WIN && !m_acc) begin
                        m_busy = 1; m_prog = 0;
                    end else if (m_idle < WIN) begin
                        m_idle++;
                    end
                end
                if (s_e && m_acc) begin
                    m_pbuf[int'(m_idx)] = m_din;
                    m_last7 = m_din[7];
                    m_acc = 0;
                end
            end
            if (s_w) begin
                if (m_low < MINL) m_low++;
                m_din = din;
            end else begin
                m_low = 0;
            end
            m_pw = s_w;
            m_pr = s_r;
        end
    end

    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R5 R6 busy", int'(busy), int'(m_busy));
            chk("R10 dout_en", int'(dout_en), int'(e_oe));
            chk("R8 R9 R10 dout", int'(dout), int'(e_dout));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v, input int len);
        @(negedge clk);
        addr = a; din = v; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        v = dout;
        chk("R10 read enable", int'(dout_en), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk("R10 released", int'(dout_en), 0);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!busy && n < WIN + 40) begin @(negedge clk); n++; end
        while (busy && n < WIN + PRG + 80) begin @(negedge clk); n++; end
        idle(2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        idle(2);

        // R11 reset state
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 dout_en after reset", int'(dout_en), 0);
        rd(16'h0010, v);
        chk("R11 erased byte", int'(v), 8'hFF);

        // single byte, status polling
        wr(16'h0005, 8'hA5, 3);
        chk("R5 not busy inside window", int'(busy), 0);
        idle(WIN + 4);
        chk("R5 busy after window", int'(busy), 1);
        rd(16'h0005, v);
        chk("R8 status bit7 inverted", int'(v[7]), 0);
        chk("R8 status low bits", int'(v[5:0]), 0);
        rd(16'h0005, v2);
        chk("R9 toggle flips", int'(v2[6]), int'(!v[6]));
        wait_done();
        rd(16'h0005, v);
        chk("R6 committed byte", int'(v), 8'hA5);
        rd(16'h0005, v2);
        chk("R9 toggling stops", int'(v2), 8'hA5);

        // page load with a foreign page in the middle
        wr(16'h0081, 8'h11, 2); idle(5);
        wr(16'h0085, 8'h22, 2); idle(5);
        wr(16'h0105, 8'h33, 2); idle(5);
        wr(16'h0082, 8'h44, 2);
        wait_done();
        rd(16'h0081, v); chk("R4 page byte 1", int'(v), 8'h11);
        rd(16'h0085, v); chk("R4 page byte 5", int'(v), 8'h22);
        rd(16'h0082, v); chk("R4 page byte 2", int'(v), 8'h44);
        rd(16'h0105, v); chk("R4 foreign page ignored", int'(v), 8'hFF);
        rd(16'h0080, v); chk("R6 unloaded byte kept", int'(v), 8'hFF);

        // noise pulse
        wr(16'h0010, 8'h55, 1);
        idle(WIN + 10);
        chk("R2 short strobe no busy", int'(busy), 0);
        rd(16'h0010, v); chk("R2 short strobe no data", int'(v), 8'hFF);

        // blocked writes
        @(negedge clk); addr = 16'h0011; din = 8'h66; ce_n = 0; oe_n = 0; we_n = 0;
        idle(4); ce_n = 1; oe_n = 1; we_n = 1;
        @(negedge clk); ce_n = 1; we_n = 0; idle(4); we_n = 1;
        idle(WIN + 10);
        chk("R1 blocked strobes no busy", int'(busy), 0);
        rd(16'h0011, v); chk("R1 blocked strobes no data", int'(v), 8'hFF);

        // address from first active cycle, data from last
        @(negedge clk); addr = 16'h0020; din = 8'h01; oe_n = 1; ce_n = 0; we_n = 1;
        @(negedge clk); we_n = 0;
        @(negedge clk); addr = 16'h0030; din = 8'h02;
        @(negedge clk); din = 8'h77;
        @(negedge clk); ce_n = 1;
        @(negedge clk); we_n = 1;
        wait_done();
        rd(16'h0020, v); chk("R3 captured address and data", int'(v), 8'h77);
        rd(16'h0030, v); chk("R3 later address unused", int'(v), 8'hFF);

        // write during busy
        wr(16'h0040, 8'h12, 2);
        idle(WIN + 4);
        wr(16'h0041, 8'h34, 3);
        wait_done();
        idle(WIN + 10);
        chk("R7 no page after busy write", int'(busy), 0);
        rd(16'h0041, v); chk("R7 busy write dropped", int'(v), 8'hFF);
        rd(16'h0040, v); chk("R6 earlier byte stored", int'(v), 8'h12);

        // long page load, same entry rewritten
        for (int k = 0; k < 8; k++) begin
            wr(16'h0103, 8'h90 + 8'(k), 2);
            idle(12);
            chk("R5 window held open", int'(busy), 0);
        end
        wait_done();
        rd(16'h0103, v); chk("R4 newest load kept", int'(v), 8'h97);

        // aliasing of the storage depth
        wr(16'h1205, 8'h5A, 2);
        wait_done();
        rd(16'h0005, v); chk("R10 alias low address", int'(v), 8'h5A);
        rd(16'h0205, v); chk("R10 alias high address", int'(v), 8'h5A);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule